// File: doc/BRIEF.md
# Consumer-aware result latency scoreboard

This block sits beside the issue logic of a floating-point pipeline and decides, cycle by cycle, whether a waiting instruction may issue. When a producer issues, the scoreboard records how long its destination register stays unusable. That time depends on the producer's class and, for divide and square root, on precision. The consumer side presents its class and two source register numbers, and the block answers with a single combinational issue-allowed bit.

Some producers reach a memory store or a float-to-integer move later than they reach other consumers. For this reason each register entry keeps its base countdown together with a small extra delay. The divide and square-root units are not pipelined, so each has its own reuse countdown. A new operation aimed at a busy unit is held back. Operand values, renaming and queue selection are outside this block.

Top module: `lat_scoreboard`

## Requirements
- R1: After reset every register is ready for any consumer, both unit-busy outputs are low, and issue_ok is high for every source pair and every consumer class.
- R2: A multiply (class code 1) issued in cycle c allows an ordinary consumer of its destination from cycle c+4, and a store (code 8) or float-to-integer move (code 6) consumer from cycle c+6.
- R3: The first half of a conditional move (code 2) gives 4 cycles to any consumer. The second half (code 3) gives 4 cycles to ordinary consumers and 6 to store or float-to-integer consumers.
- R4: A divide (code 4) makes its result usable after 12 cycles when prod_dbl is 0 and after 15 cycles when prod_dbl is 1, for every consumer class.
- R5: A divide holds div_busy high for 9 (single) or 12 (double) cycles after its issue cycle. While div_busy is high, a divide consumer (code 4) is refused and a square-root consumer (code 5) is not.
- R6: A square root (code 5) makes its result usable after 18 (single) or 33 (double) cycles. It holds sqrt_busy high for 15 or 30 cycles, and a square-root consumer is refused during that time.
- R7: A float-to-integer move (code 6) has a 3-cycle result latency and an integer-to-float move (code 7) has a 4-cycle result latency, with no extra delay for store consumers.
- R8: A no-op (code 0), a store (code 8), an ordinary integer operation (code 9) and codes 10 to 15 never make any register not ready and never set a unit busy.
- R9: When a register is written again, the newer producer's timing replaces the older one, even if the older one would have finished later.
- R10: issue_ok is high only when both source registers are ready for the presented consumer class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_valid | input | 1 | A producer issues this cycle |
| prod_cls | input | 4 | Producer class code |
| prod_dbl | input | 1 | Producer precision, 1 = double |
| prod_dst | input | 5 | Producer destination register |
| cons_cls | input | 4 | Consumer class code |
| cons_src_a | input | 5 | Consumer first source register |
| cons_src_b | input | 5 | Consumer second source register |
| issue_ok | output | 1 | Consumer may issue this cycle |
| div_busy | output | 1 | Divide unit cannot take a new operation |
| sqrt_busy | output | 1 | Square-root unit cannot take a new operation |

## Verification
Every producer class code is swept at both precisions against an ordinary, a store and a float-to-integer consumer, and issue_ok is checked in each of the following 36 cycles. This separates the base latency from the extra delay for late consumers, and shows that non-writing classes leave the table untouched. Separate sweeps of divide and square root compare each unit's busy window and same-unit refusal with the result latency, and show that one unit being busy does not block the other. Directed cases cover a shorter producer overwriting a longer one on the same register and a dependency that arrives through the second source only.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

    localparam int NREG    = 32;
    localparam int REG_W   = $clog2(NREG);
    localparam int CNT_W   = 6;
    localparam int EXTRA_W = 2;

    typedef enum logic [3:0] {
        CLS_NOP    = 4'd0,
        CLS_FMUL   = 4'd1,
        CLS_FCMOV1 = 4'd2,
        CLS_FCMOV2 = 4'd3,
        CLS_FDIV   = 4'd4,
        CLS_FSQRT  = 4'd5,
        CLS_FTOI   = 4'd6,
        CLS_ITOF   = 4'd7,
        CLS_FST    = 4'd8,
        CLS_INT    = 4'd9
    } op_cls_e;

    typedef struct packed {
        logic               wr;
        logic [CNT_W-1:0]   lat;
        logic [EXTRA_W-1:0] extra;
    } prod_timing_t;

    function automatic prod_timing_t prod_timing(input logic [3:0] c, input logic dbl);
        prod_timing_t t;
        t = '{wr: 1'b0, lat: '0, extra: '0};
        case (c)
            CLS_FMUL:   t = '{wr: 1'b1, lat: CNT_W'(4), extra: EXTRA_W'(2)};
            CLS_FCMOV1: t = '{wr: 1'b1, lat: CNT_W'(4), extra: EXTRA_W'(0)};
            CLS_FCMOV2: t = '{wr: 1'b1, lat: CNT_W'(4), extra: EXTRA_W'(2)};
            CLS_FDIV:   t = '{wr: 1'b1, lat: dbl ? CNT_W'(15) : CNT_W'(12), extra: EXTRA_W'(0)};
            CLS_FSQRT:  t = '{wr: 1'b1, lat: dbl ? CNT_W'(33) : CNT_W'(18), extra: EXTRA_W'(0)};
            CLS_FTOI:   t = '{wr: 1'b1, lat: CNT_W'(3), extra: EXTRA_W'(0)};
            CLS_ITOF:   t = '{wr: 1'b1, lat: CNT_W'(4), extra: EXTRA_W'(0)};
            default:    t = '{wr: 1'b0, lat: '0, extra: '0};
        endcase
        return t;
    endfunction

    function automatic logic [CNT_W-1:0] reuse_time(input logic [3:0] c, input logic dbl);
        case (c)
            CLS_FDIV:  return dbl ? CNT_W'(12) : CNT_W'(9);
            CLS_FSQRT: return dbl ? CNT_W'(30) : CNT_W'(15);
            default:   return '0;
        endcase
    endfunction

    function automatic logic late_consumer(input logic [3:0] c);
        return (c == CLS_FST) || (c == CLS_FTOI);
    endfunction

endpackage

// File: rtl/lsb_reg_timer.sv
module lsb_reg_timer #(
    parameter int CNT_W   = 6,
    parameter int EXTRA_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [CNT_W-1:0]   load_total,
    input  logic [EXTRA_W-1:0] load_extra,
    output logic               ready_norm,
    output logic               ready_late
);
    logic [CNT_W-1:0]   remain;
    logic [EXTRA_W-1:0] extra;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            extra  <= '0;
        end else if (load) begin
            remain <= load_total;
            extra  <= load_extra;
        end else if (remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign ready_late = (remain == '0);
    assign ready_norm = (remain <= CNT_W'(extra));
endmodule

// File: rtl/lsb_unit_timer.sv
module lsb_unit_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy
);
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/lat_scoreboard.sv
module lat_scoreboard
    import lsb_pkg::*;
#(
    parameter int N_REGS = lsb_pkg::NREG,
    parameter int CW     = lsb_pkg::CNT_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     prod_valid,
    input  logic [3:0]               prod_cls,
    input  logic                     prod_dbl,
    input  logic [$clog2(N_REGS)-1:0] prod_dst,
    input  logic [3:0]               cons_cls,
    input  logic [$clog2(N_REGS)-1:0] cons_src_a,
    input  logic [$clog2(N_REGS)-1:0] cons_src_b,
    output logic                     issue_ok,
    output logic                     div_busy,
    output logic                     sqrt_busy
);
    localparam int RW     = $clog2(N_REGS);
    localparam int N_UNIT = 2;

    prod_timing_t      ptime;
    logic              wr_en;
    logic [CW-1:0]     total;
    logic [CW-1:0]     reuse_m1;
    logic [N_REGS-1:0] ready_norm;
    logic [N_REGS-1:0] ready_late;
    logic [N_UNIT-1:0] unit_busy;
    logic              late;
    logic              src_a_ok;
    logic              src_b_ok;
    logic              unit_ok;

    assign ptime    = prod_timing(prod_cls, prod_dbl);
    assign wr_en    = prod_valid && ptime.wr;
    assign total    = CW'(ptime.lat) + CW'(ptime.extra) - CW'(1);
    assign reuse_m1 = CW'(reuse_time(prod_cls, prod_dbl)) - CW'(1);

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        lsb_reg_timer #(
            .CNT_W   (CW),
            .EXTRA_W (EXTRA_W)
        ) u_timer (
            .clk        (clk),
            .rst        (rst),
            .load       (wr_en && (prod_dst == RW'(g))),
            .load_total (total),
            .load_extra (ptime.extra),
            .ready_norm (ready_norm[g]),
            .ready_late (ready_late[g])
        );
    end

    for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
        localparam logic [3:0] UCLS = (u == 0) ? CLS_FDIV : CLS_FSQRT;
        lsb_unit_timer #(
            .CNT_W (CW)
        ) u_unit (
            .clk      (clk),
            .rst      (rst),
            .load     (prod_valid && (prod_cls == UCLS)),
            .load_val (reuse_m1),
            .busy     (unit_busy[u])
        );
    end

    assign div_busy  = unit_busy[0];
    assign sqrt_busy = unit_busy[1];

    assign late     = late_consumer(cons_cls);
    assign src_a_ok = late ? ready_late[cons_src_a] : ready_norm[cons_src_a];
    assign src_b_ok = late ? ready_late[cons_src_b] : ready_norm[cons_src_b];
    assign unit_ok  = !((cons_cls == CLS_FDIV) && div_busy) &&
                      !((cons_cls == CLS_FSQRT) && sqrt_busy);
    assign issue_ok = src_a_ok && src_b_ok && unit_ok;
endmodule

// File: rtl/lsb_checker.sv
module lsb_checker
    import lsb_pkg::*;
#(
    parameter int N_REGS = lsb_pkg::NREG
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      prod_valid,
    input logic [3:0]                prod_cls,
    input logic                      prod_dbl,
    input logic [$clog2(N_REGS)-1:0] prod_dst,
    input logic [3:0]                cons_cls,
    input logic                      issue_ok,
    input logic                      div_busy,
    input logic                      sqrt_busy,
    input logic [N_REGS-1:0]         ready_norm,
    input logic [N_REGS-1:0]         ready_late
);
    logic writes;
    assign writes = prod_timing(prod_cls, prod_dbl).wr;

    // R2, R4, R6, R7: a writing producer makes its destination not ready next cycle
    p_writer_blocks_r2: assert property (@(posedge clk) disable iff (rst)
        (prod_valid && writes) |=> !ready_norm[$past(prod_dst)]);

    // R8: without a write, no register goes from ready to not ready
    p_no_new_block_r8: assert property (@(posedge clk) disable iff (rst)
        !(prod_valid && writes) |=> (($past(ready_norm) & ~ready_norm) == '0));

    // R5: a divide makes the divide unit busy
    p_div_sets_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (prod_valid && prod_cls == CLS_FDIV) |=> div_busy);

    // R5: an idle divide unit stays idle without a divide
    p_div_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (!div_busy && !(prod_valid && prod_cls == CLS_FDIV)) |=> !div_busy);

    // R5: a busy divide unit refuses a divide consumer
    p_div_refuse_r5: assert property (@(posedge clk) disable iff (rst)
        (cons_cls == CLS_FDIV && div_busy) |-> !issue_ok);

    // R6: a busy square-root unit refuses a square-root consumer
    p_sqrt_refuse_r6: assert property (@(posedge clk) disable iff (rst)
        (cons_cls == CLS_FSQRT && sqrt_busy) |-> !issue_ok);

    // R3: late readiness never precedes ordinary readiness
    p_late_after_norm_r3: assert property (@(posedge clk) disable iff (rst)
        ((ready_late & ~ready_norm) == '0));
endmodule

bind lat_scoreboard lsb_checker #(.N_REGS(N_REGS)) u_lsb_checker (
    .clk        (clk),
    .rst        (rst),
    .prod_valid (prod_valid),
    .prod_cls   (prod_cls),
    .prod_dbl   (prod_dbl),
    .prod_dst   (prod_dst),
    .cons_cls   (cons_cls),
    .issue_ok   (issue_ok),
    .div_busy   (div_busy),
    .sqrt_busy  (sqrt_busy),
    .ready_norm (ready_norm),
    .ready_late (ready_late)
);

// File: tb/test_lat_scoreboard.sv
`timescale 1ns/1ps
module test_lat_scoreboard;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prod_valid = 1'b0;
    logic [3:0] prod_cls = 4'd0;
    logic       prod_dbl = 1'b0;
    logic [4:0] prod_dst = 5'd0;
    logic [3:0] cons_cls = 4'd9;
    logic [4:0] cons_src_a = 5'd0;
    logic [4:0] cons_src_b = 5'd0;
    logic       issue_ok;
    logic       div_busy;
    logic       sqrt_busy;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lat_scoreboard i_lat_scoreboard (
        .clk        (clk),
        .rst        (rst),
        .prod_valid (prod_valid),
        .prod_cls   (prod_cls),
        .prod_dbl   (prod_dbl),
        .prod_dst   (prod_dst),
        .cons_cls   (cons_cls),
        .cons_src_a (cons_src_a),
        .cons_src_b (cons_src_b),
        .issue_ok   (issue_ok),
        .div_busy   (div_busy),
        .sqrt_busy  (sqrt_busy)
    );

    function automatic int e_lat(int c, bit d);
        case (c)
            1, 2, 3: return 4;
            4:       return d ? 15 : 12;
            5:       return d ? 33 : 18;
            6:       return 3;
            7:       return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int e_extra(int c);
        return (c == 1 || c == 3) ? 2 : 0;
    endfunction

    function automatic int e_reuse(int c, bit d);
        if (c == 4) return d ? 12 : 9;
        if (c == 5) return d ? 30 : 15;
        return 0;
    endfunction

    function automatic string req_of(int c);
        case (c)
            1:       return "R2";
            2, 3:    return "R3";
            4:       return "R4";
            5:       return "R6";
            6, 7:    return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic chk(input logic act, input logic exp, input string req, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        prod_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic issue_prod(input int c, input bit d, input int dst);
        prod_valid = 1'b1;
        prod_cls   = 4'(c);
        prod_dbl   = d;
        prod_dst   = 5'(dst);
    endtask

    // result latency sweep for one producer and one consumer class
    task automatic sweep_result(input int c, input bit d, input int cc);
        int need;
        bit late;
        late = (cc == 8) || (cc == 6);
        need = e_lat(c, d) + (late ? e_extra(c) : 0);
        do_reset();
        @(negedge clk);
        issue_prod(c, d, 7);
        cons_cls = 4'(cc); cons_src_a = 5'd7; cons_src_b = 5'd0;
        for (int k = 1; k <= 36; k++) begin
            @(negedge clk);
            prod_valid = 1'b0;
            #1;
            chk(issue_ok, logic'(k >= need), req_of(c), $sformatf("cls %0d dbl %0d cons %0d k %0d", c, d, cc, k));
        end
    endtask

    // unit reuse sweep
    task automatic sweep_unit(input int c, input bit d);
        int r;
        string req;
        r = e_reuse(c, d);
        req = (c == 4) ? "R5" : "R6";
        do_reset();
        @(negedge clk);
        issue_prod(c, d, 9);
        cons_cls = 4'(c); cons_src_a = 5'd0; cons_src_b = 5'd1;
        for (int k = 1; k <= 34; k++) begin
            @(negedge clk);
            prod_valid = 1'b0;
            #1;
            chk(div_busy,  logic'(c == 4 && k < r), req, $sformatf("div_busy cls %0d dbl %0d k %0d", c, d, k));
            chk(sqrt_busy, logic'(c == 5 && k < r), req, $sformatf("sqrt_busy cls %0d dbl %0d k %0d", c, d, k));
            chk(issue_ok,  logic'(k >= r), req, $sformatf("unit consumer cls %0d dbl %0d k %0d", c, d, k));
        end
    endtask

    initial begin
        int cons_list [3];
        cons_list[0] = 9; cons_list[1] = 8; cons_list[2] = 6;

        // R1: reset state
        do_reset();
        #1;
        chk(div_busy, 1'b0, "R1", "div_busy after reset");
        chk(sqrt_busy, 1'b0, "R1", "sqrt_busy after reset");
        for (int r = 0; r < 32; r++) begin
            for (int cc = 0; cc < 10; cc++) begin
                cons_src_a = 5'(r); cons_src_b = 5'(31 - r); cons_cls = 4'(cc);
                #0.1;
                chk(issue_ok, 1'b1, "R1", $sformatf("ready after reset reg %0d cons %0d", r, cc));
            end
        end

        // R2..R4, R6..R8: every class code, both precisions, three consumer kinds
        for (int c = 0; c < 16; c++)
            for (int d = 0; d < 2; d++)
                for (int i = 0; i < 3; i++)
                    sweep_result(c, d[0], cons_list[i]);

        // R5, R6: unit reuse windows
        for (int d = 0; d < 2; d++) begin
            sweep_unit(4, d[0]);
            sweep_unit(5, d[0]);
        end

        // R5: square-root consumer not blocked by busy divide
        do_reset();
        @(negedge clk);
        issue_prod(4, 1'b0, 3);
        @(negedge clk);
        prod_valid = 1'b0;
        cons_cls = 4'd5; cons_src_a = 5'd0; cons_src_b = 5'd1;
        #1;
        chk(issue_ok, 1'b1, "R5", "sqrt consumer while divide busy");
        chk(div_busy, 1'b1, "R5", "divide busy during cross check");

        // R9: newer short producer overrides older long one
        do_reset();
        @(negedge clk);
        issue_prod(5, 1'b1, 3);
        @(negedge clk);
        prod_valid = 1'b0;
        @(negedge clk);
        issue_prod(1, 1'b0, 3);
        cons_cls = 4'd9; cons_src_a = 5'd3; cons_src_b = 5'd3;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            prod_valid = 1'b0;
            #1;
            chk(issue_ok, logic'(k >= 4), "R9", $sformatf("rewrite k %0d", k));
        end

        // R10: dependency through second source only
        do_reset();
        @(negedge clk);
        issue_prod(7, 1'b0, 4);
        cons_cls = 4'd9; cons_src_a = 5'd0; cons_src_b = 5'd4;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            prod_valid = 1'b0;
            #1;
            chk(issue_ok, logic'(k >= 4), "R10", $sformatf("second source k %0d", k));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end
endmodule